// File: doc/BRIEF.md
# Prefix-Adder Booth-Multiplier ALU

This block is a purely combinational two's-complement arithmetic and logic unit. Two operand words and a 3-bit operation code go in; a result word and a flag that is high when the result is all zeros come out in the same cycle. The unit covers add, subtract, the low half of a signed multiply, three bitwise logic functions, inversion of the first operand, and a logical shift whose direction and distance come from the second operand.

All carry resolution goes through one parallel-prefix adder design with a Sklansky topology: each prefix level doubles the span of every group. Subtraction feeds the inverted second operand and a carry-in of one into that adder. The multiplier recodes the second operand into radix-4 signed digits, so a W-bit word needs only W/2 partial products. A carry-save tree of 3:2 compressors reduces these to two rows. A second copy of the same prefix adder then adds those two rows. The unit has no clock, no state and no handshake: operands held on the inputs give a stable result after the combinational delay.

Top module: `prefix_booth_alu`

## Requirements
- R1: With op = 000 the result is (a + b) mod 2^W; for W = 32, 0x11111111 plus 0x22222222 gives 0x33333333, and a carry out of the top bit is dropped.
- R2: With op = 001 the result is (a - b) mod 2^W.
- R3: With op = 010 the result is the low W bits of the signed product a × b, formed from radix-4 Booth digits taken from overlapping bit triplets of b (an implied 0 below bit 0) and a carry-save reduction.
- R4: With op = 011, 100 and 101 the result is a AND b, a OR b and a XOR b, bit for bit.
- R5: With op = 110 the result is the bitwise inverse of a, and b has no effect on it.
- R6: With op = 111 and b[log2 W] = 0 the result is a shifted left by b[log2(W)-1:0] places, with zeros entering at the bottom (b[5] and b[4:0] for W = 32).
- R7: With op = 111 and b[log2 W] = 1 the result is a shifted right logically by b[log2(W)-1:0] places, with zeros entering at the top.
- R8: The zero output is 1 exactly when every bit of the result is 0, for every opcode.
- R9: In the shift operation, the bits of b above b[log2 W] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W (32) | First operand; multiplicand; value that is shifted |
| b | input | W (32) | Second operand; Booth-recoded multiplier; shift control |
| op | input | 3 | Operation code (000 add, 001 sub, 010 mul, 011 and, 100 or, 101 xor, 110 not a, 111 shift) |
| y | output | W (32) | Result word |
| zero | output | 1 | High when y is all zeros |

## Verification
The unit holds no state, so a fault inside it shows up on y in the same evaluation as the operands that reach it. There is no delayed symptom to wait for. A wrong span in a prefix level corrupts carries only for operand pairs whose carry chain crosses that span. A wrong Booth digit or a misrouted compressor output corrupts only the products whose recoding uses that digit or row. For this reason the bench sweeps every operand pair and every opcode on an 8-bit copy, and adds directed and pseudo-random 32-bit vectors that exercise long carry chains and large-magnitude digits.

// File: rtl/palu_pkg.sv
package palu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MUL = 3'b010,
    OP_AND = 3'b011,
    OP_OR  = 3'b100,
    OP_XOR = 3'b101,
    OP_NOT = 3'b110,
    OP_SHF = 3'b111
  } op_e;

  // Row count left after one layer of 3:2 compression.
  function automatic int csa_next(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Row count after l layers.
  function automatic int csa_rows(input int n, input int l);
    int r;
    r = n;
    for (int i = 0; i < l; i++) r = csa_next(r);
    return r;
  endfunction

  // Layers needed to reach two rows.
  function automatic int csa_layers(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = csa_next(r);
      c++;
    end
    return c;
  endfunction
endpackage

// File: rtl/palu_prefix_add.sv
module palu_prefix_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s
);
  localparam int LG = $clog2(W);

  logic [W-1:0] hp;
  logic [W-1:0] g [LG+1];
  logic [W-1:0] p [LG+1];
  logic [W-1:0] c;
  logic         unused_top;

  assign hp   = x ^ y;
  assign p[0] = hp;
  // carry-in folded into the generate of bit 0
  assign g[0] = (x & y) | {{(W-1){1'b0}}, hp[0] & cin};

  for (genvar k = 0; k < LG; k++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (((i >> k) & 1) == 1) begin : g_join
        localparam int J = ((i >> k) << k) - 1;
        assign g[k+1][i] = g[k][i] | (p[k][i] & g[k][J]);
        assign p[k+1][i] = p[k][i] & p[k][J];
      end else begin : g_keep
        assign g[k+1][i] = g[k][i];
        assign p[k+1][i] = p[k][i];
      end
    end
  end

  assign c = {g[LG][W-2:0], cin};
  assign s = hp ^ c;
  assign unused_top = ^{g[LG][W-1], p[LG]};
endmodule

// File: rtl/palu_booth_mult.sv
module palu_booth_mult
  import palu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod
);
  localparam int ND = W / 2;
  localparam int NR = ND + 1;
  localparam int LV = csa_layers(NR);

  logic [W-1:0] pp [NR];
  logic [W-1:0] fix;

  // radix-4 recoding: one digit per bit pair of b
  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [2:0]   trip;
    logic         one, two, neg;
    logic [W-1:0] mag;
    if (i == 0) begin : g_lsb
      assign trip = {b[1], b[0], 1'b0};
    end else begin : g_mid
      assign trip = b[2*i+1 : 2*i-1];
    end
    always_comb begin
      one = 1'b0;
      two = 1'b0;
      neg = 1'b0;
      unique case (trip)
        3'b001, 3'b010: one = 1'b1;
        3'b011:         two = 1'b1;
        3'b100:         begin two = 1'b1; neg = 1'b1; end
        3'b101, 3'b110: begin one = 1'b1; neg = 1'b1; end
        default:        ;
      endcase
    end
    assign mag         = two ? (a << 1) : (one ? a : '0);
    // negative digit: inverted row plus a 1 at the digit weight (in fix)
    assign pp[i]       = (neg ? ~mag : mag) << (2 * i);
    assign fix[2*i]    = neg;
    assign fix[2*i+1]  = 1'b0;
  end
  assign pp[ND] = fix;

  // carry-save reduction
  for (genvar l = 0; l < LV; l++) begin : g_stg
    localparam int N  = csa_rows(NR, l);
    localparam int NO = csa_next(N);
    localparam int NG = N / 3;
    logic [W-1:0] rin  [N];
    logic [W-1:0] rout [NO];
    for (genvar r = 0; r < N; r++) begin : g_in
      if (l == 0) begin : g_first
        assign rin[r] = pp[r];
      end else begin : g_next
        assign rin[r] = g_stg[l-1].rout[r];
      end
    end
    for (genvar q = 0; q < NG; q++) begin : g_csa
      assign rout[2*q]   = rin[3*q] ^ rin[3*q+1] ^ rin[3*q+2];
      assign rout[2*q+1] = ((rin[3*q] & rin[3*q+1]) | (rin[3*q] & rin[3*q+2]) |
                            (rin[3*q+1] & rin[3*q+2])) << 1;
    end
    for (genvar r = 0; r < N % 3; r++) begin : g_pass
      assign rout[2*NG+r] = rin[3*NG+r];
    end
  end

  palu_prefix_add #(.W(W)) u_cpa (
    .x   (g_stg[LV-1].rout[0]),
    .y   (g_stg[LV-1].rout[1]),
    .cin (1'b0),
    .s   (prod)
  );
endmodule

// File: rtl/prefix_booth_alu.sv
module prefix_booth_alu
  import palu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y,
  output logic         zero
);
  localparam int SH = $clog2(W);

  op_e          opc;
  logic         is_sub;
  logic [W-1:0] add_y, add_s, mul_p, shf_y;
  logic [SH-1:0] amt;

  assign opc    = op_e'(op);
  assign is_sub = (opc == OP_SUB);
  assign add_y  = is_sub ? ~b : b;
  assign amt    = b[SH-1:0];

  palu_prefix_add #(.W(W)) u_add (
    .x   (a),
    .y   (add_y),
    .cin (is_sub),
    .s   (add_s)
  );

  palu_booth_mult #(.W(W)) u_mul (
    .a    (a),
    .b    (b),
    .prod (mul_p)
  );

  assign shf_y = b[SH] ? (a >> amt) : (a << amt);

  always_comb begin
    unique case (opc)
      OP_ADD, OP_SUB: y = add_s;
      OP_MUL:         y = mul_p;
      OP_AND:         y = a & b;
      OP_OR:          y = a | b;
      OP_XOR:         y = a ^ b;
      OP_NOT:         y = ~a;
      default:        y = shf_y;
    endcase
  end

  assign zero = ~|y;
endmodule

// File: rtl/palu_chk.sv
module palu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [2:0]   op,
  input logic [W-1:0] y,
  input logic         zero
);
  always_comb begin
    if (!$isunknown({a, b, op})) begin
      if (op == 3'b000) begin
        p_add_r1: assert (y == W'(a + b)) else $error("R1 add mismatch");
      end
      if (op == 3'b001) begin
        p_sub_r2: assert (y == W'(a - b)) else $error("R2 sub mismatch");
      end
      if (op == 3'b010) begin
        p_mul_r3: assert (y == W'(a * b)) else $error("R3 mul mismatch");
      end
      if (op == 3'b011) begin
        p_and_r4: assert ((y & ~a) == '0 && (y & ~b) == '0) else $error("R4 and mismatch");
      end
      if (op == 3'b110) begin
        p_not_r5: assert ((y ^ a) == {W{1'b1}}) else $error("R5 not mismatch");
      end
      if (op == 3'b101 && a == b) begin
        p_zero_r8: assert (zero) else $error("R8 zero flag low on zero xor");
      end
    end
  end
endmodule

bind prefix_booth_alu palu_chk #(.W(W)) u_chk (
  .a    (a),
  .b    (b),
  .op   (op),
  .y    (y),
  .zero (zero)
);

// File: tb/tb_prefix_booth_alu.sv
module tb_prefix_booth_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] a, b, y;
  logic [2:0]  op;
  logic        zero;
  logic [7:0]  a8, b8, y8;
  logic [2:0]  op8;
  logic        zero8;

  prefix_booth_alu #(.W(32)) dut  (.a(a), .b(b), .op(op), .y(y), .zero(zero));
  prefix_booth_alu #(.W(8))  dut8 (.a(a8), .b(b8), .op(op8), .y(y8), .zero(zero8));

  function automatic logic [31:0] ref32(input logic [2:0] o, input logic [31:0] x, input logic [31:0] z);
    logic [63:0] pr;
    pr = 64'(x) * 64'(z);
    case (o)
      3'd0: return x + z;
      3'd1: return x - z;
      3'd2: return pr[31:0];
      3'd3: return x & z;
      3'd4: return x | z;
      3'd5: return x ^ z;
      3'd6: return ~x;
      default: return z[5] ? (x >> z[4:0]) : (x << z[4:0]);
    endcase
  endfunction

  function automatic logic [7:0] ref8(input logic [2:0] o, input logic [7:0] x, input logic [7:0] z);
    logic [15:0] pr;
    pr = 16'(x) * 16'(z);
    case (o)
      3'd0: return x + z;
      3'd1: return x - z;
      3'd2: return pr[7:0];
      3'd3: return x & z;
      3'd4: return x | z;
      3'd5: return x ^ z;
      3'd6: return ~x;
      default: return z[3] ? (x >> z[2:0]) : (x << z[2:0]);
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4, 3'd5: return "R4";
      3'd6: return "R5";
      default: return "R6/R7";
    endcase
  endfunction

  task automatic check32(input string tag, input logic [2:0] o, input logic [31:0] x,
                         input logic [31:0] z, input logic [31:0] exp);
    @(negedge clk);
    op = o; a = x; b = z;
    #5;
    n_chk++;
    if (y !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h y=%h expected %h", tag, o, x, z, y, exp);
    end
    n_chk++;
    if (zero !== (exp == 32'd0)) begin
      n_bad++;
      $display("FAIL R8 op=%0d a=%h b=%h zero=%b expected %b", o, x, z, zero, exp == 32'd0);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf1, lf2;
    a = '0; b = '0; op = '0;
    a8 = '0; b8 = '0; op8 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state with all-zero inputs: add of zeros, R8 flag set
    check32("R1", 3'd0, 32'h0, 32'h0, 32'h0);
    // R1 directed
    check32("R1", 3'd0, 32'h11111111, 32'h22222222, 32'h33333333);
    check32("R1", 3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000);
    // R2
    check32("R2", 3'd1, 32'd5, 32'd7, 32'hFFFFFFFE);
    check32("R2", 3'd1, 32'h80000000, 32'h1, 32'h7FFFFFFF);
    // R3 signed low product
    check32("R3", 3'd2, 32'hFFFFFFFD, 32'd7, 32'hFFFFFFEB);
    check32("R3", 3'd2, 32'h80000000, 32'hFFFFFFFF, 32'h80000000);
    check32("R3", 3'd2, 32'hAAAAAAAA, 32'h55555555, ref32(3'd2, 32'hAAAAAAAA, 32'h55555555));
    // R4
    check32("R4", 3'd3, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000);
    check32("R4", 3'd4, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF);
    check32("R4", 3'd5, 32'h12345678, 32'h12345678, 32'h0);
    // R5: b changes, result must not
    check32("R5", 3'd6, 32'h0000FFFF, 32'h00000000, 32'hFFFF0000);
    check32("R5", 3'd6, 32'h0000FFFF, 32'hDEADBEEF, 32'hFFFF0000);
    // R6 / R7
    check32("R6", 3'd7, 32'h00000001, 32'h0000001F, 32'h80000000);
    check32("R6", 3'd7, 32'h80000001, 32'h00000001, 32'h00000002);
    check32("R7", 3'd7, 32'h80000000, 32'h0000003F, 32'h00000001);
    check32("R7", 3'd7, 32'hFFFFFFFF, 32'h00000024, 32'h0FFFFFFF);
    // R9: upper b bits set, b[5]=0, amount 4
    check32("R9", 3'd7, 32'h0000000F, 32'hFFFFFFC4, 32'h000000F0);
    check32("R9", 3'd7, 32'hF0000000, 32'hABCDEF64, 32'h0F000000);

    // pseudo-random 32-bit vectors for every opcode
    lf1 = 32'hACE1_2468;
    lf2 = 32'h1357_BDF0;
    for (int i = 0; i < 400; i++) begin
      lf1 = {lf1[30:0], lf1[31] ^ lf1[21] ^ lf1[1] ^ lf1[0]};
      lf2 = lf2 * 32'd1664525 + 32'd1013904223;
      for (int o = 0; o < 8; o++) begin
        check32(tag_of(3'(o)), 3'(o), lf1, lf2, ref32(3'(o), lf1, lf2));
      end
    end

    // exhaustive sweep of the 8-bit copy: R1..R9 over every pair
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int z = 0; z < 256; z++) begin
          logic [7:0] e;
          op8 = 3'(o); a8 = 8'(x); b8 = 8'(z);
          #1;
          e = ref8(3'(o), 8'(x), 8'(z));
          n_chk++;
          if (y8 !== e) begin
            n_bad++;
            $display("FAIL %s w8 op=%0d a=%h b=%h y=%h expected %h", tag_of(3'(o)), o, x, z, y8, e);
          end
          n_chk++;
          if (zero8 !== (e == 8'd0)) begin
            n_bad++;
            $display("FAIL R8 w8 op=%0d a=%h b=%h zero=%b expected %b", o, x, z, zero8, e == 8'd0);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule